// File: doc/BRIEF.md
# Issue Queue Occupancy and Squash Tracker

This block keeps the slot bookkeeping of an out-of-order issue queue. Each slot holds an instruction tag (its sequence number) and two flags: occupied, and parked. An insert takes the lowest-numbered free slot and lowers the free-entry count. An issue, named by slot index, frees the slot again. Instructions that must not run speculatively are inserted parked. They stay ineligible until the commit side sends a release carrying their sequence number. After that they are eligible like any other entry.

On a squash the block records a bound sequence number. It then removes, one per cycle, every still-occupied (unissued) entry whose sequence number is above the bound. The youngest entry goes first. Each removal returns one free entry. While the walk runs, busy is high, and inserts and issues are refused. The eligibility vector it drives feeds a separate selection stage. Wakeup, selection and memory ordering live elsewhere.

Top module: `iq_occ_squash`

## Requirements
- R1: After reset, free_cnt equals DEPTH, full is 0, busy is 0, kill_vld is 0 and elig is all zeros.
- R2: An insert (ins_vld) is taken when a slot is free, busy is 0 and sq_vld is 0. The slot taken is the lowest-numbered free slot, which ins_slot shows in the same cycle. free_cnt is one lower on the next cycle.
- R3: full is 1 exactly when free_cnt is 0. An insert that is not taken (full, busy or sq_vld) raises ins_err in the same cycle and changes no slot and no count.
- R4: An issue (iss_vld, iss_slot) of an eligible slot while busy is 0 frees that slot. Its elig bit clears and free_cnt rises by one on the next cycle. An issue of a slot that is not eligible has no effect.
- R5: An insert with ins_nonspec=0 sets its elig bit (bit index = slot) on the next cycle. An insert with ins_nonspec=1 occupies the slot with its elig bit held at 0.
- R6: A release (rel_vld, rel_seq) that matches the sequence number of an occupied parked slot sets that slot's elig bit on the next cycle. A release that matches no such slot raises rel_err in the same cycle and changes nothing.
- R7: A squash (sq_vld) with nonzero sq_seq while busy is 0 and at least one slot is occupied sets busy from the next cycle. Each busy cycle that still has an occupied slot with sequence number greater than sq_seq drives kill_vld=1 with kill_slot naming the one with the largest sequence number. That slot is freed, and free_cnt rises by one on the next cycle. The first busy cycle with no such slot is the last busy cycle. Slots with sequence number not above sq_seq are untouched.
- R8: A squash with sq_seq equal to 0, or arriving while no slot is occupied, leaves busy at 0 and kills nothing.
- R9: A parked slot removed by a squash is no longer pending. A later release of its sequence number raises rel_err.
- R10: While busy is 1, inserts are refused with ins_err and issues have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_vld | input | 1 | Insert request |
| ins_seq | input | 16 | Sequence number of the inserted instruction |
| ins_nonspec | input | 1 | Inserted instruction waits for a release |
| ins_slot | output | IDX_W | Slot an insert in this cycle would take |
| ins_err | output | 1 | Insert request refused this cycle |
| full | output | 1 | No free entry |
| free_cnt | output | CNT_W | Number of free entries |
| iss_vld | input | 1 | Issue request |
| iss_slot | input | IDX_W | Slot being issued |
| rel_vld | input | 1 | Release request from commit side |
| rel_seq | input | 16 | Sequence number being released |
| rel_err | output | 1 | Release matched no parked entry |
| sq_vld | input | 1 | Squash request |
| sq_seq | input | 16 | Squash bound; younger entries are removed |
| busy | output | 1 | Squash walk in progress |
| kill_vld | output | 1 | A slot is removed by the walk this cycle |
| kill_slot | output | IDX_W | Slot removed this cycle |
| elig | output | DEPTH | Per-slot eligible-to-issue flags |

## Verification
The hardest situation to reach is a squash walk over a queue that is completely full. The queue must hold a mix of issued holes, a released non-speculative entry, a still-parked entry and entries on both sides of the bound, so that the removal order differs from slot order. The stimulus fills the queue, issues one slot and refills that hole with a younger tag, and leaves one non-speculative entry parked. It then squashes at a bound in the middle of the tags. During the walk it presses inserts and issues against busy. A scoreboard queue, filled from a model sorted by descending tag, is compared kill by kill. A release of the squashed parked tag afterwards proves it left the pending set.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int SEQ_W = 16;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef struct packed {
        logic valid;
        logic parked;
        seq_t seq;
    } slot_t;

    function automatic logic is_younger(seq_t a, seq_t b);
        return a > b;
    endfunction

    function automatic logic is_eligible(slot_t s);
        return s.valid && !s.parked;
    endfunction

endpackage

// File: rtl/iq_free_pick.sv
module iq_free_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] free_mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_mask[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/iq_seq_match.sv
module iq_seq_match
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  slot_t [DEPTH-1:0] ents,
    input  seq_t              key,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [DEPTH-1:0] match;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = ents[g].valid && ents[g].parked && (ents[g].seq == key);
        end
    endgenerate

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/iq_young_pick.sv
module iq_young_pick
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  slot_t [DEPTH-1:0] ents,
    input  seq_t              bound,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    logic [DEPTH-1:0] cand;
    seq_t             best;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cand
            assign cand[g] = ents[g].valid && is_younger(ents[g].seq, bound);
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cand[i] && (!found || is_younger(ents[i].seq, best))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = ents[i].seq;
            end
        end
    end
endmodule

// File: rtl/iq_occ_squash.sv
module iq_occ_squash
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_vld,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic             ins_nonspec,
    output logic [IDX_W-1:0] ins_slot,
    output logic             ins_err,
    output logic             full,
    output logic [CNT_W-1:0] free_cnt,
    input  logic             iss_vld,
    input  logic [IDX_W-1:0] iss_slot,
    input  logic             rel_vld,
    input  logic [SEQ_W-1:0] rel_seq,
    output logic             rel_err,
    input  logic             sq_vld,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             busy,
    output logic             kill_vld,
    output logic [IDX_W-1:0] kill_slot,
    output logic [DEPTH-1:0] elig
);
    slot_t [DEPTH-1:0] ents;
    seq_t              sq_bound;
    logic [DEPTH-1:0]  free_mask;
    logic [DEPTH-1:0]  valid_vec;
    logic              free_found;
    logic              rel_hit;
    logic [IDX_W-1:0]  rel_idx;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic              ins_ok;
    logic              iss_ok;
    logic              sq_go;
    logic              occupied;
    logic [CNT_W-1:0]  cnt_nxt;
    seq_t              kill_seq;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_flags
            assign free_mask[g] = !ents[g].valid;
            assign valid_vec[g] = ents[g].valid;
            assign elig[g]      = is_eligible(ents[g]);
        end
    endgenerate

    iq_free_pick #(.DEPTH(DEPTH)) u_alloc (
        .free_mask (free_mask),
        .found     (free_found),
        .idx       (ins_slot)
    );

    iq_seq_match #(.DEPTH(DEPTH)) u_match (
        .ents    (ents),
        .key     (rel_seq),
        .hit     (rel_hit),
        .hit_idx (rel_idx)
    );

    iq_young_pick #(.DEPTH(DEPTH)) u_young (
        .ents  (ents),
        .bound (sq_bound),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign full      = (free_cnt == '0);
    assign occupied  = (free_cnt != CNT_W'(DEPTH));
    assign ins_ok    = ins_vld && free_found && !busy && !sq_vld;
    assign ins_err   = ins_vld && !ins_ok;
    assign iss_ok    = iss_vld && !busy && (int'(iss_slot) < DEPTH) && is_eligible(ents[iss_slot]);
    assign rel_err   = rel_vld && !rel_hit;
    assign sq_go     = sq_vld && !busy && (sq_seq != '0) && occupied;
    assign kill_vld  = busy && pick_found;
    assign kill_slot = pick_idx;
    assign kill_seq  = ents[pick_idx].seq;

    always_comb begin
        cnt_nxt = free_cnt;
        if (ins_ok)   cnt_nxt = cnt_nxt - CNT_W'(1);
        if (iss_ok)   cnt_nxt = cnt_nxt + CNT_W'(1);
        if (kill_vld) cnt_nxt = cnt_nxt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ents     <= '0;
            free_cnt <= CNT_W'(DEPTH);
            busy     <= 1'b0;
            sq_bound <= '0;
        end else begin
            if (ins_ok) begin
                ents[ins_slot].valid  <= 1'b1;
                ents[ins_slot].parked <= ins_nonspec;
                ents[ins_slot].seq    <= ins_seq;
            end
            if (iss_ok) begin
                ents[iss_slot].valid <= 1'b0;
            end
            if (rel_vld && rel_hit) begin
                ents[rel_idx].parked <= 1'b0;
            end
            if (kill_vld) begin
                ents[kill_slot].valid  <= 1'b0;
                ents[kill_slot].parked <= 1'b0;
            end
            free_cnt <= cnt_nxt;
            if (sq_go) begin
                busy     <= 1'b1;
                sq_bound <= sq_seq;
            end else if (busy && !pick_found) begin
                busy <= 1'b0;
            end
        end
    end

    // R3
    cnt_consistent_chk: assert property (@(posedge clk) disable iff (rst)
        int'(free_cnt) == DEPTH - $countones(valid_vec));

    // R2
    ins_slot_free_chk: assert property (@(posedge clk) disable iff (rst)
        ins_ok |-> !ents[ins_slot].valid);

    // R7
    kill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        kill_vld |-> (ents[kill_slot].valid && (ents[kill_slot].seq > sq_bound)));

    // R7
    kill_order_chk: assert property (@(posedge clk) disable iff (rst)
        (kill_vld && $past(kill_vld)) |-> (kill_seq < $past(kill_seq)));

    // R8
    sq_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sq_vld && (sq_seq == '0) && !busy) |=> !busy);

    // R10
    busy_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (free_cnt >= $past(free_cnt)));

endmodule

// File: tb/iq_occ_squash_tb.sv
module iq_occ_squash_tb;
    localparam int DEPTH = 8;
    localparam int IDX_W = 3;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ins_vld = 1'b0;
    logic [15:0]      ins_seq = '0;
    logic             ins_nonspec = 1'b0;
    logic [IDX_W-1:0] ins_slot;
    logic             ins_err;
    logic             full;
    logic [CNT_W-1:0] free_cnt;
    logic             iss_vld = 1'b0;
    logic [IDX_W-1:0] iss_slot = '0;
    logic             rel_vld = 1'b0;
    logic [15:0]      rel_seq = '0;
    logic             rel_err;
    logic             sq_vld = 1'b0;
    logic [15:0]      sq_seq = '0;
    logic             busy;
    logic             kill_vld;
    logic [IDX_W-1:0] kill_slot;
    logic [DEPTH-1:0] elig;

    always #10 clk = ~clk;

    iq_occ_squash #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .ins_vld(ins_vld), .ins_seq(ins_seq), .ins_nonspec(ins_nonspec),
        .ins_slot(ins_slot), .ins_err(ins_err), .full(full), .free_cnt(free_cnt),
        .iss_vld(iss_vld), .iss_slot(iss_slot),
        .rel_vld(rel_vld), .rel_seq(rel_seq), .rel_err(rel_err),
        .sq_vld(sq_vld), .sq_seq(sq_seq), .busy(busy),
        .kill_vld(kill_vld), .kill_slot(kill_slot), .elig(elig)
    );

    int n_chk = 0;
    int n_fail = 0;
    int exp_kill[$];

    bit m_v[DEPTH];
    bit m_p[DEPTH];
    int m_s[DEPTH];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int m_free_cnt();
        int c = 0;
        for (int i = 0; i < DEPTH; i++) if (!m_v[i]) c++;
        return c;
    endfunction

    function automatic int m_free_slot();
        for (int i = 0; i < DEPTH; i++) if (!m_v[i]) return i;
        return -1;
    endfunction

    function automatic int m_elig();
        int e = 0;
        for (int i = 0; i < DEPTH; i++) if (m_v[i] && !m_p[i]) e |= (1 << i);
        return e;
    endfunction

    task automatic check_state(string req);
        @(negedge clk);
        chk({req, " free_cnt"}, int'(free_cnt), m_free_cnt());
        chk({req, " full"}, int'(full), (m_free_cnt() == 0) ? 1 : 0);
        chk({req, " elig"}, int'(elig), m_elig());
    endtask

    task automatic do_insert(int seq, bit ns);
        int s;
        @(negedge clk);
        ins_vld = 1'b1; ins_seq = 16'(seq); ins_nonspec = ns;
        #1;
        if (m_free_cnt() > 0) begin
            s = m_free_slot();
            chk("R2 ins_slot", int'(ins_slot), s);
            chk("R2 ins_err", int'(ins_err), 0);
            m_v[s] = 1'b1; m_p[s] = ns; m_s[s] = seq;
        end else begin
            chk("R3 ins_err when full", int'(ins_err), 1);
        end
        @(posedge clk); #1;
        ins_vld = 1'b0;
    endtask

    task automatic do_issue(int slot);
        @(negedge clk);
        iss_vld = 1'b1; iss_slot = IDX_W'(slot);
        if (m_v[slot] && !m_p[slot]) m_v[slot] = 1'b0;
        @(posedge clk); #1;
        iss_vld = 1'b0;
    endtask

    task automatic do_release(int seq, string req);
        bit hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_v[i] && m_p[i] && m_s[i] == seq) begin
                hit = 1'b1; m_p[i] = 1'b0;
            end
        end
        @(negedge clk);
        rel_vld = 1'b1; rel_seq = 16'(seq);
        #1;
        chk({req, " rel_err"}, int'(rel_err), hit ? 0 : 1);
        @(posedge clk); #1;
        rel_vld = 1'b0;
    endtask

    task automatic do_squash(int seq);
        int best;
        int bi;
        if (seq != 0 && m_free_cnt() < DEPTH) begin
            forever begin
                bi = -1; best = 0;
                for (int i = 0; i < DEPTH; i++) begin
                    if (m_v[i] && m_s[i] > seq && (bi < 0 || m_s[i] > best)) begin
                        bi = i; best = m_s[i];
                    end
                end
                if (bi < 0) break;
                exp_kill.push_back(bi);
                m_v[bi] = 1'b0; m_p[bi] = 1'b0;
            end
        end
        @(negedge clk);
        sq_vld = 1'b1; sq_seq = 16'(seq);
        @(posedge clk); #1;
        sq_vld = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        chk("R7 walk finishes", int'(busy), 0);
    endtask

    // scoreboard monitor for squash kills
    always @(negedge clk) begin
        if (!rst && kill_vld) begin
            if (exp_kill.size() == 0) chk("R7 unexpected kill", int'(kill_slot), -1);
            else chk("R7 kill order", int'(kill_slot), exp_kill.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_p[i] = 0; m_s[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check_state("R1 reset");
        chk("R1 busy", int'(busy), 0);
        chk("R1 kill_vld", int'(kill_vld), 0);

        do_insert(10, 0);
        do_insert(11, 1);
        do_insert(12, 0);
        do_insert(13, 0);
        check_state("R5 nonspec parked");

        do_issue(2);
        check_state("R4 issue frees");
        do_issue(1);
        check_state("R4 parked issue ignored");

        do_release(11, "R6 match");
        check_state("R6 released");
        do_release(99, "R6 no match");
        check_state("R6 no change");

        do_insert(14, 0);
        do_insert(15, 1);
        do_insert(16, 0);
        do_insert(17, 0);
        do_insert(18, 0);
        check_state("R3 full");
        do_insert(19, 0);
        check_state("R3 refused insert");

        do_squash(13);
        @(negedge clk);
        chk("R7 busy", int'(busy), 1);
        ins_vld = 1'b1; ins_seq = 16'd30; ins_nonspec = 1'b0;
        iss_vld = 1'b1; iss_slot = '0;
        #1;
        chk("R10 ins_err while busy", int'(ins_err), 1);
        @(posedge clk); #1;
        ins_vld = 1'b0; iss_vld = 1'b0;
        wait_idle();
        check_state("R10 after walk");
        chk("R7 all kills seen", exp_kill.size(), 0);

        do_release(15, "R9 squashed parked");

        do_squash(0);
        @(negedge clk);
        chk("R8 zero seq no busy", int'(busy), 0);

        do_issue(0);
        do_issue(1);
        do_issue(3);
        check_state("R4 empty");
        do_squash(5);
        @(negedge clk);
        chk("R8 empty no busy", int'(busy), 0);
        check_state("R8 empty unchanged");
        chk("R8 no kills", exp_kill.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule